// File: doc/BRIEF.md
# Read-Only Fuse Cache Window

This block presents a one-time-programmable fuse array, held as 32-bit rows, to a bus master as a small byte-addressed read-only window. A master asks for 1 to 4 bytes at any byte address. The block works out whether those bytes sit in one row or straddle two neighbouring rows. It fetches the rows it needs through a row-read port, one row per cycle, and returns the bytes packed little-endian from bit 0 of the response.

Writes are never carried out. They are answered with an error response and also latch a sticky error status. Requests with an illegal byte count, or that reach past the end of the window, are refused in the same way. The fuse store itself sits outside the block. Its row-read port answers one cycle after a request.

Top module: `fuse_window`

## Requirements
- R1: The window is 0xC00 bytes. An access whose last byte (address + size − 1) is at or above 0xC00 gets an error response one cycle after acceptance and starts no row fetch.
- R2: `req_size` is the byte count in binary. Only 1, 2, 3 and 4 are legal. Any other value gets an error response one cycle after acceptance and starts no row fetch.
- R3: A legal read fetches row address/4 first. When (address + size − 1)/4 differs from it, that row (always the next one up) is fetched in the following cycle. Each fetch is one cycle of `row_req` high with the row number on `row_idx`.
- R4: For a read accepted in cycle t, `row_req` is high in cycle t+1. `rsp_valid` is high in cycle t+3 when one row is read, and in cycle t+4 when two rows are read.
- R5: Byte k of `rsp_data` (bits 8k+7..8k) equals the fuse byte at address + k. Byte j of row r lives at address 4r + j. Bits at and above 8×size are zero.
- R6: A write gets an error response one cycle after acceptance, starts no row fetch, and leaves later reads of the same bytes unchanged.
- R7: `rsp_err` is high only together with `rsp_valid`, for exactly that one response cycle. Error responses carry zero data.
- R8: `err_sticky` goes high in the cycle of any error response and stays high until `err_clear` is sampled high. If an error and a clear coincide, the error wins.
- R9: `busy` is high from the cycle after a read is accepted up to, but not including, its response cycle. Requests presented while `busy` is high are ignored.
- R10: After reset, `busy`, `rsp_valid`, `rsp_err`, `row_req` and `err_sticky` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write (always refused), 0 = read |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | 3 | Number of bytes, 1 to 4 |
| busy | output | 1 | A read is in flight |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Read bytes, little-endian from bit 0 |
| rsp_err | output | 1 | Response is a refusal |
| err_sticky | output | 1 | Latched error status |
| err_clear | input | 1 | Clears `err_sticky` |
| row_req | output | 1 | Row fetch request |
| row_idx | output | IDX_W | Row number being fetched |
| row_valid | input | 1 | Row data present, one cycle after `row_req` |
| row_data | input | 32 | Fetched row contents |

## Verification
The bench aims at reads that straddle a row boundary, such as offset 3 with size 2 and offset 1 with size 4. A design that joined the two rows the wrong way round, or fetched only one row, would return bytes from the wrong row there. It probes the last row and the exact window edge (0xBFF/1 passes, 0xBFE/4 and 0xC00/1 are refused), where an off-by-one range test would either refuse a legal read or fetch past the end. It also sends sizes 0, 5 and 7, and a write made while a clear is pending, which a clear-wins sticky bit would lose. It sends a write during a busy read, which a design that does not hold off requests would answer with a stray error. Short reads catch unmasked upper bytes.

// File: rtl/fuse_window_pkg.sv
package fuse_window_pkg;

  localparam int ROW_BITS  = 32;
  localparam int ROW_BYTES = ROW_BITS / 8;
  localparam int SIZE_W    = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE_LO,
    SEQ_ISSUE_HI,
    SEQ_WAIT
  } seq_state_t;

  // Legal byte counts are 1..ROW_BYTES.
  function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
    return (sz != '0) && (int'(sz) <= ROW_BYTES);
  endfunction

  // Shift the joined row pair down by the byte offset and keep sz bytes.
  function automatic logic [ROW_BITS-1:0] pack_bytes(
      input logic [2*ROW_BITS-1:0] pair,
      input logic [1:0]            off,
      input logic [SIZE_W-1:0]     sz);
    logic [2*ROW_BITS-1:0] shifted;
    logic [ROW_BITS-1:0]   res;
    shifted = pair >> {off, 3'b000};
    res = '0;
    for (int b = 0; b < ROW_BYTES; b++) begin
      if (b < int'(sz)) res[b*8 +: 8] = shifted[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/fw_req_decode.sv
module fw_req_decode
  import fuse_window_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WINDOW_BYTES = 3072,
  parameter int IDX_W        = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [IDX_W-1:0]  hi_idx,
  output logic              spans_two,
  output logic              good
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WINDOW_BYTES);

  logic [ADDR_W:0] last_byte;
  logic            in_range;
  logic            size_ok;

  always_comb begin
    last_byte = {1'b0, addr} + (ADDR_W+1)'(size) - (ADDR_W+1)'(1);
    lo_idx    = IDX_W'(addr >> 2);
    hi_idx    = IDX_W'(last_byte >> 2);
    in_range  = last_byte < LIMIT;
    size_ok   = size_legal(size);
    good      = in_range && size_ok;
    spans_two = lo_idx != hi_idx;
  end

  // R3
  always_comb begin
    adjacent_rows_chk: assert (!good || (hi_idx == lo_idx) || (hi_idx == lo_idx + IDX_W'(1)));
  end

endmodule

// File: rtl/fw_result_pack.sv
module fw_result_pack
  import fuse_window_pkg::*;
(
  input  logic                two_rows,
  input  logic [ROW_BITS-1:0] lo_row,
  input  logic [ROW_BITS-1:0] last_row,
  input  logic [1:0]          off,
  input  logic [SIZE_W-1:0]   size,
  output logic [ROW_BITS-1:0] packed_word
);

  logic [2*ROW_BITS-1:0] pair;

  always_comb begin
    pair        = two_rows ? {last_row, lo_row} : {{ROW_BITS{1'b0}}, last_row};
    packed_word = pack_bytes(pair, off, size);
  end

endmodule

// File: rtl/fw_row_seq.sv
module fw_row_seq
  import fuse_window_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_off,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [IDX_W-1:0]    lo_idx,
  input  logic [IDX_W-1:0]    hi_idx,
  input  logic                spans_two,
  input  logic                good,
  input  logic                row_valid,
  input  logic [ROW_BITS-1:0] row_data,
  input  logic [ROW_BITS-1:0] packed_word,
  output logic                busy,
  output logic                row_req,
  output logic [IDX_W-1:0]    row_idx,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [ROW_BITS-1:0] rsp_data,
  output logic                err_event,
  output logic                two_q,
  output logic [ROW_BITS-1:0] lo_data_q,
  output logic [1:0]          off_q,
  output logic [SIZE_W-1:0]   size_q
);

  seq_state_t       state;
  logic [IDX_W-1:0] lo_q;
  logic [IDX_W-1:0] hi_q;
  logic             accept;
  logic             launch_read;

  assign busy        = state != SEQ_IDLE;
  assign accept      = req_valid && !busy;
  assign err_event   = accept && (req_write || !good);
  assign launch_read = accept && !req_write && good;
  assign row_req     = (state == SEQ_ISSUE_LO) || (state == SEQ_ISSUE_HI);
  assign row_idx     = (state == SEQ_ISSUE_HI) ? hi_q : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      two_q     <= 1'b0;
      off_q     <= '0;
      size_q    <= '0;
      lo_data_q <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      unique case (state)
        SEQ_IDLE: begin
          if (err_event) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
          end else if (launch_read) begin
            lo_q   <= lo_idx;
            hi_q   <= hi_idx;
            two_q  <= spans_two;
            off_q  <= req_off;
            size_q <= req_size;
            state  <= SEQ_ISSUE_LO;
          end
        end
        SEQ_ISSUE_LO: state <= two_q ? SEQ_ISSUE_HI : SEQ_WAIT;
        SEQ_ISSUE_HI: begin
          if (row_valid) lo_data_q <= row_data;
          state <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (row_valid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= packed_word;
            state     <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R6
  write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_write) |=> (rsp_valid && rsp_err && !row_req));

  // R4
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_write && good) |=> (row_req && row_idx == $past(lo_idx)));

  // R1
  refused_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !good) |=> (!row_req && rsp_err));

  // R7
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

endmodule

// File: rtl/fw_err_status.sv
module fw_err_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic sticky
);

  always_ff @(posedge clk) begin
    if (!rst_n)       sticky <= 1'b0;
    else if (set_evt) sticky <= 1'b1;
    else if (clr)     sticky <= 1'b0;
  end

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> sticky);

  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !sticky);

endmodule

// File: rtl/fuse_window.sv
module fuse_window
  import fuse_window_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WINDOW_BYTES = 3072,
  parameter int IDX_W        = ADDR_W - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SIZE_W-1:0]   req_size,
  output logic                busy,
  output logic                rsp_valid,
  output logic [ROW_BITS-1:0] rsp_data,
  output logic                rsp_err,
  output logic                err_sticky,
  input  logic                err_clear,
  output logic                row_req,
  output logic [IDX_W-1:0]    row_idx,
  input  logic                row_valid,
  input  logic [ROW_BITS-1:0] row_data
);

  logic [IDX_W-1:0]    lo_idx;
  logic [IDX_W-1:0]    hi_idx;
  logic                spans_two;
  logic                good;
  logic                err_event;
  logic                two_q;
  logic [ROW_BITS-1:0] lo_data_q;
  logic [1:0]          off_q;
  logic [SIZE_W-1:0]   size_q;
  logic [ROW_BITS-1:0] packed_word;

  fw_req_decode #(
    .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .size(req_size), .lo_idx(lo_idx), .hi_idx(hi_idx),
    .spans_two(spans_two), .good(good)
  );

  fw_row_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_addr[1:0]), .req_size(req_size), .lo_idx(lo_idx), .hi_idx(hi_idx),
    .spans_two(spans_two), .good(good), .row_valid(row_valid), .row_data(row_data),
    .packed_word(packed_word), .busy(busy), .row_req(row_req), .row_idx(row_idx),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .err_event(err_event), .two_q(two_q), .lo_data_q(lo_data_q),
    .off_q(off_q), .size_q(size_q)
  );

  fw_result_pack u_pack (
    .two_rows(two_q), .lo_row(lo_data_q), .last_row(row_data),
    .off(off_q), .size(size_q), .packed_word(packed_word)
  );

  fw_err_status u_err (
    .clk(clk), .rst_n(rst_n), .set_evt(err_event), .clr(err_clear), .sticky(err_sticky)
  );

  // R7
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R5
  read_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $past(row_valid));

endmodule

// File: tb/sim_fuse_window.sv
module sim_fuse_window;

  localparam int ADDR_W = 12;
  localparam int WIN    = 3072;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int NROWS  = WIN / 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_size = '0;
  logic              busy;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              rsp_err;
  logic              err_sticky;
  logic              err_clear = 1'b0;
  logic              row_req;
  logic [IDX_W-1:0]  row_idx;
  logic              row_valid = 1'b0;
  logic [31:0]       row_data = '0;

  logic [31:0] fuse [NROWS];
  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  fuse_window #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .err_sticky(err_sticky),
    .err_clear(err_clear), .row_req(row_req), .row_idx(row_idx),
    .row_valid(row_valid), .row_data(row_data)
  );

  // registered fuse row model
  always_ff @(posedge clk) begin
    row_valid <= row_req;
    row_data  <= fuse[row_idx];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fuse_byte(input int a);
    logic [31:0] w;
    w = fuse[a / 4];
    return w[(a % 4) * 8 +: 8];
  endfunction

  task automatic access(input bit wr, input int a, input int sz, input bit junk, input bit clr);
    bit          bad;
    int          lat;
    int          first_r;
    int          last_r;
    logic [31:0] exp_d;
    @(negedge clk);
    while (busy) @(negedge clk);
    bad     = wr || sz < 1 || sz > 4 || (a + sz - 1) >= WIN;
    first_r = a / 4;
    last_r  = (a + sz - 1) / 4;
    lat     = bad ? 1 : ((first_r != last_r) ? 4 : 3);
    exp_d   = '0;
    if (!bad) for (int k = 0; k < sz; k++) exp_d[k*8 +: 8] = fuse_byte(a + k);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(a);
    req_size  = 3'(sz);
    err_clear = clr;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      err_clear = 1'b0;
      if (i == 1 && junk) begin
        req_write = 1'b1;
        req_size  = 3'd4;
      end else if (!junk || i == lat) begin
        req_valid = 1'b0;
      end
      if (!bad && i == 1) begin
        // R3 R4
        check(row_req && int'(row_idx) == first_r, "R4/R3 first fetch", row_idx, first_r);
        check(busy, "R9 busy in flight", busy, 1);
      end
      if (!bad && i == 2) begin
        if (lat == 4) check(row_req && int'(row_idx) == last_r, "R3 second fetch", row_idx, last_r);
        else          check(!row_req, "R3 single fetch", row_req, 0);
      end
      if (bad && i == 1) check(!row_req, "R1/R2/R6 no fetch on refusal", row_req, 0);
      if (i < lat) begin
        check(!rsp_valid, "R4 early response", rsp_valid, 0);
      end else begin
        check(rsp_valid, "R4 response timing", rsp_valid, 1);
        check(rsp_err == bad, bad ? "R1/R2/R6 error flag" : "R7 no error on read", rsp_err, bad);
        check(rsp_data == exp_d, "R5 data", rsp_data, exp_d);
        check(!busy, "R9 busy released", busy, 0);
        if (bad) check(err_sticky, "R8 sticky set", err_sticky, 1);
      end
    end
    if (junk) begin
      @(negedge clk);
      // R9: write presented while busy must have been ignored
      check(!rsp_valid && !rsp_err, "R9 ignored while busy", rsp_err, 0);
    end else begin
      @(negedge clk);
      check(!rsp_err, "R7 single-cycle error", rsp_err, 0);
    end
  endtask

  task automatic clear_sticky();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check(!err_sticky, "R8 sticky cleared", err_sticky, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NROWS; i++) fuse[i] = (32'(i) * 32'h0100_0193) ^ 32'hA5C3_0F17;
    repeat (3) @(negedge clk);
    // R10
    check(!busy && !rsp_valid && !rsp_err && !row_req && !err_sticky, "R10 reset state",
          {busy, rsp_valid, rsp_err, row_req, err_sticky}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !err_sticky, "R10 idle after reset", busy, 0);

    // R5 R4 aligned and unaligned single-row reads
    access(0, 0, 4, 0, 0);
    access(0, 1, 1, 0, 0);
    access(0, 2, 2, 0, 0);
    access(0, 5, 3, 0, 0);
    access(0, 12, 3, 0, 0);
    // R3 reads crossing a row boundary
    access(0, 3, 2, 0, 0);
    access(0, 1, 4, 0, 0);
    access(0, 6, 3, 0, 0);
    access(0, 203, 4, 0, 0);
    // R1 window edges
    access(0, 'hBFC, 4, 0, 0);
    access(0, 'hBFF, 1, 0, 0);
    access(0, 'hBFE, 4, 0, 0);
    clear_sticky();
    access(0, 'hC00, 1, 0, 0);
    clear_sticky();
    // R2 illegal sizes
    access(0, 16, 0, 0, 0);
    access(0, 16, 5, 0, 0);
    access(0, 16, 7, 0, 0);
    clear_sticky();
    // R6 write refused, contents unchanged
    access(0, 8, 4, 0, 0);
    access(1, 8, 4, 0, 0);
    access(0, 8, 4, 0, 0);
    clear_sticky();
    // R8 coincident error and clear: error wins
    access(1, 20, 2, 0, 1);
    check(err_sticky, "R8 set wins over clear", err_sticky, 1);
    clear_sticky();
    // R9 write presented during a busy read is ignored
    access(0, 7, 2, 1, 0);
    check(!err_sticky, "R9 no error from ignored write", err_sticky, 0);
    access(0, 0, 4, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule